// File: doc/BRIEF.md
# Raster Panel Timing Generator

This block produces the timing skeleton of a raster display scan. It divides the module clock down to a pixel rate. It walks a horizontal position through each line and a vertical position through each frame. From those positions it drives the pixel clock, the line and frame sync pulses, a data-enable window, end-of-line and end-of-frame strobes, and the active-area coordinates that a pixel data path uses to fetch and present each pixel.

Configuration comes from four 32-bit words: a control word that holds the clock divisor, a horizontal timing word, a vertical timing word and an auxiliary word. The auxiliary word carries the output polarity controls, the sync-edge selection and the top bit of the line count. The active width is coded in units of 16 pixels minus one, and its most significant bit sits apart from the rest of the field. The active height is coded minus one, and its eleventh bit lives in the auxiliary word.

A run request starts a scan at the top-left corner of the frame. Withdrawing the request lets the current frame run to its end. The block then halts with all outputs at their inactive levels and raises a sticky done indication.

Top module: `raster_timing_gen`

## Requirements
- R1: The pixel period D equals the divisor field ctrl_word[15:8], except that the values 0 and 1 give D = 2. pix_ce is high on the last module-clock cycle of every D-cycle pixel slot and low on the others.
- R2: While running, the internal pixel clock is low for the first floor(D/2) cycles of a slot and high for the remainder. pclk_o is that clock XOR tim_x[22]. When idle, pclk_o sits at tim_x[22].
- R3: A line is laid out in this order: sync for tim_h[15:10]+1 pixels, back porch for tim_h[31:24]+1, active for (P+1)*16 with P = {tim_h[3], tim_h[9:4]}, then front porch for tim_h[23:16]+1. The line sync is high during the sync pixels of every line, blank or active.
- R4: A frame is laid out in lines, in this order: sync for tim_v[15:10]+1 lines, back porch for tim_v[31:24]+1, active for {tim_x[26], tim_v[9:0]}+1, then front porch for tim_v[23:16]+1. The frame sync is high for the whole of its sync lines.
- R5: de_o is high exactly on active pixels of active lines. During such a pixel, pos_x and pos_y give its zero-based column and row within the active area. Both are 0 whenever de_o is low.
- R6: eol_o pulses for one module clock, together with pix_ce, on the last active pixel of each active line. eof_o pulses at the same moment on the last active pixel of the last active line.
- R7: tim_x[21] inverts hsync_o and tim_x[20] inverts vsync_o. In the idle state each output rests at its inversion bit.
- R8: With tim_x[25] = 0, the syncs change at the start of a pixel slot and tim_x[24] has no effect. With tim_x[25] = 1 and tim_x[24] = 0, the syncs change when the internal pixel clock rises, which delays them by half a slot. With tim_x[25] = 1 and tim_x[24] = 1, they change on the following fall, which delays them by one whole slot. Before the first such update of a run, the syncs read inactive.
- R9: When run_en is sampled high while idle, the first pixel slot (position 0,0) begins on the next cycle, and done_o reads 0 from that cycle on.
- R10: Dropping run_en has no effect until the last slot of the current frame. If run_en is low at that point, the block goes idle on the next cycle and done_o reads 1 until a restart. If run_en is high again by then, scanning continues without a break.
- R11: After reset, the block is idle: done_o, de_o, pix_ce, eol_o and eof_o read 0 and pos_x and pos_y read 0.
- R12: The width-extension bit tim_h[3] adds 1024 pixels to the active width. The height bit tim_x[26] adds 1024 lines to the active height.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Scan request |
| ctrl_word | input | 32 | Control word, divisor in bits 15:8 |
| tim_h | input | 32 | Horizontal timing word |
| tim_v | input | 32 | Vertical timing word |
| tim_x | input | 32 | Polarity, edge selection and line-count extension |
| pix_ce | output | 1 | One-cycle pixel step enable |
| pclk_o | output | 1 | Pixel clock to the panel |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Active data window |
| pos_x | output | 11 | Active column of the current pixel |
| pos_y | output | 11 | Active row of the current pixel |
| eol_o | output | 1 | Last active pixel of a line |
| eof_o | output | 1 | Last active pixel of a frame |
| done_o | output | 1 | Sticky flag: halted at a frame boundary |

## Verification
A divider phase fault shows on pix_ce and pclk_o within one pixel slot. A horizontal counter fault shifts de_o, pos_x and hsync_o within a single line. A vertical counter or segment-boundary fault shows on vsync_o, pos_y or eof_o no later than the end of the frame in progress. Faults in the run control or the re-timing register show at the first frame boundary after run_en falls, or in the first slot after a start. The bench therefore predicts every output on every cycle over whole frames, for several divisors and for each polarity and edge setting.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int REG_W    = 32;
  localparam int PW_W     = 6;   // sync pulse field width
  localparam int PORCH_W  = 8;   // porch field width
  localparam int HBLK_W   = 7;   // active width in 16-pixel blocks, extension included
  localparam int VLIN_W   = 11;  // active height minus one, extension included
  localparam int BLK_SHIFT = 4;  // 16 pixels per block

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/rtg_pixdiv.sv
module rtg_pixdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_f,
  output logic             tick,
  output logic             rise_pt,
  output logic             pclk_raw
);
  logic [DIV_W-1:0] eff;
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] ph_q;
  logic [DIV_W-1:0] ph_d;
  logic             wrap;

  // divisors below two collapse to divide-by-two
  assign eff  = (div_f < DIV_W'(2)) ? DIV_W'(2) : div_f;
  assign half = eff >> 1;
  assign wrap = (ph_q >= eff - DIV_W'(1));

  always_comb begin
    ph_d = ph_q;
    if (!run) begin
      ph_d = '0;
    end else if (wrap) begin
      ph_d = '0;
    end else begin
      ph_d = ph_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign tick     = run && wrap;
  assign rise_pt  = run && (ph_q == half - DIV_W'(1));
  assign pclk_raw = run && (ph_q >= half);
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
  parameter int CNT_W = 12,
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] sync_len,
  input  logic [CNT_W-1:0] bp_len,
  input  logic [CNT_W-1:0] act_len,
  input  logic [CNT_W-1:0] fp_len,
  output logic             at_end,
  output logic             in_sync,
  output logic             in_act,
  output logic             act_last,
  output logic [POS_W-1:0] act_idx
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] act_start;
  logic [CNT_W-1:0] act_stop;
  logic [CNT_W-1:0] total;

  // segment order: sync, back porch, active, front porch
  assign act_start = sync_len + bp_len;
  assign act_stop  = act_start + act_len;
  assign total     = act_stop + fp_len;

  assign at_end   = (cnt_q == total - CNT_W'(1));
  assign in_sync  = (cnt_q < sync_len);
  assign in_act   = (cnt_q >= act_start) && (cnt_q < act_stop);
  assign act_last = (cnt_q == act_stop - CNT_W'(1));
  assign act_idx  = POS_W'(cnt_q - act_start);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = at_end ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
  import rtg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic frame_last,
  output logic running,
  output logic done
);
  run_state_e st_q;
  run_state_e st_d;
  logic       done_q;
  logic       done_d;

  always_comb begin
    st_d   = st_q;
    done_d = done_q;
    case (st_q)
      ST_IDLE: begin
        if (run_en) begin
          st_d   = ST_RUN;
          done_d = 1'b0;
        end
      end
      ST_RUN: begin
        // halt only at a frame boundary
        if (frame_last && !run_en) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  assign running = (st_q == ST_RUN);
  assign done    = done_q;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 12,
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [31:0]      ctrl_word,
  input  logic [31:0]      tim_h,
  input  logic [31:0]      tim_v,
  input  logic [31:0]      tim_x,
  output logic             pix_ce,
  output logic             pclk_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [POS_W-1:0] pos_x,
  output logic [POS_W-1:0] pos_y,
  output logic             eol_o,
  output logic             eof_o,
  output logic             done_o
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  // field decode
  logic [DIV_W-1:0]  div_f;
  logic [PW_W-1:0]   h_pw_f;
  logic [PORCH_W-1:0] h_bp_f;
  logic [PORCH_W-1:0] h_fp_f;
  logic [HBLK_W-1:0] h_blk_f;
  logic [PW_W-1:0]   v_pw_f;
  logic [PORCH_W-1:0] v_bp_f;
  logic [PORCH_W-1:0] v_fp_f;
  logic [VLIN_W-1:0] v_lin_f;
  logic              inv_pix;
  logic              inv_line;
  logic              inv_frame;
  logic              edge_en;
  logic              edge_fall;
  logic              unused_cfg_bits;

  assign div_f     = ctrl_word[8 +: DIV_W];
  assign h_pw_f    = tim_h[15:10];
  assign h_fp_f    = tim_h[23:16];
  assign h_bp_f    = tim_h[31:24];
  assign h_blk_f   = {tim_h[3], tim_h[9:4]};
  assign v_pw_f    = tim_v[15:10];
  assign v_fp_f    = tim_v[23:16];
  assign v_bp_f    = tim_v[31:24];
  assign v_lin_f   = {tim_x[26], tim_v[9:0]};
  assign inv_frame = tim_x[20];
  assign inv_line  = tim_x[21];
  assign inv_pix   = tim_x[22];
  assign edge_fall = tim_x[24];
  assign edge_en   = tim_x[25];
  assign unused_cfg_bits = ^{ctrl_word[31:16], ctrl_word[7:0], tim_h[2:0],
                             tim_x[31:27], tim_x[23], tim_x[19:0]};

  logic [CNT_W-1:0] h_sync_len, h_bp_len, h_act_len, h_fp_len;
  logic [CNT_W-1:0] v_sync_len, v_bp_len, v_act_len, v_fp_len;

  assign h_sync_len = CNT_W'(h_pw_f) + CNT_W'(1);
  assign h_bp_len   = CNT_W'(h_bp_f) + CNT_W'(1);
  assign h_fp_len   = CNT_W'(h_fp_f) + CNT_W'(1);
  assign h_act_len  = (CNT_W'(h_blk_f) + CNT_W'(1)) << BLK_SHIFT;
  assign v_sync_len = CNT_W'(v_pw_f) + CNT_W'(1);
  assign v_bp_len   = CNT_W'(v_bp_f) + CNT_W'(1);
  assign v_fp_len   = CNT_W'(v_fp_f) + CNT_W'(1);
  assign v_act_len  = CNT_W'(v_lin_f) + CNT_W'(1);

  // run control
  logic running;
  logic done_i;
  logic tick;
  logic rise_pt;
  logic pclk_raw;
  logic frame_last;

  rtg_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .run_en     (run_en),
    .frame_last (frame_last),
    .running    (running),
    .done       (done_i)
  );

  rtg_pixdiv #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (running),
    .div_f    (div_f),
    .tick     (tick),
    .rise_pt  (rise_pt),
    .pclk_raw (pclk_raw)
  );

  // two position axes share one counter design
  localparam int N_AXIS = 2;
  localparam int AX_H   = 0;
  localparam int AX_V   = 1;

  logic [CNT_W-1:0] ax_sync [N_AXIS];
  logic [CNT_W-1:0] ax_bp   [N_AXIS];
  logic [CNT_W-1:0] ax_act  [N_AXIS];
  logic [CNT_W-1:0] ax_fp   [N_AXIS];
  logic             ax_adv  [N_AXIS];
  logic             ax_end  [N_AXIS];
  logic             ax_sy   [N_AXIS];
  logic             ax_in   [N_AXIS];
  logic             ax_last [N_AXIS];
  logic [POS_W-1:0] ax_idx  [N_AXIS];

  assign ax_sync[AX_H] = h_sync_len;
  assign ax_bp[AX_H]   = h_bp_len;
  assign ax_act[AX_H]  = h_act_len;
  assign ax_fp[AX_H]   = h_fp_len;
  assign ax_sync[AX_V] = v_sync_len;
  assign ax_bp[AX_V]   = v_bp_len;
  assign ax_act[AX_V]  = v_act_len;
  assign ax_fp[AX_V]   = v_fp_len;

  // horizontal steps per pixel, vertical steps at the end of each line
  assign ax_adv[AX_H] = tick;
  assign ax_adv[AX_V] = tick && ax_end[AX_H];

  for (genvar g = 0; g < N_AXIS; g++) begin : g_axis
    rtg_axis #(.CNT_W(CNT_W), .POS_W(POS_W)) u_axis (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .clr      (!running),
      .adv      (ax_adv[g]),
      .sync_len (ax_sync[g]),
      .bp_len   (ax_bp[g]),
      .act_len  (ax_act[g]),
      .fp_len   (ax_fp[g]),
      .at_end   (ax_end[g]),
      .in_sync  (ax_sy[g]),
      .in_act   (ax_in[g]),
      .act_last (ax_last[g]),
      .act_idx  (ax_idx[g])
    );
  end

  assign frame_last = tick && ax_end[AX_H] && ax_end[AX_V];

  // sync re-timing to the selected pixel-clock edge
  logic hs_live, vs_live;
  logic hs_q, vs_q, hs_d, vs_d;
  logic sync_load;

  assign hs_live   = running && ax_sy[AX_H];
  assign vs_live   = running && ax_sy[AX_V];
  assign sync_load = edge_fall ? tick : rise_pt;

  always_comb begin
    hs_d = hs_q;
    vs_d = vs_q;
    if (!running) begin
      hs_d = 1'b0;
      vs_d = 1'b0;
    end else if (sync_load) begin
      hs_d = hs_live;
      vs_d = vs_live;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      hs_q <= hs_d;
      vs_q <= vs_d;
    end
  end

  // outputs
  logic de_i;
  logic eol_i;

  assign de_i    = running && ax_in[AX_H] && ax_in[AX_V];
  assign eol_i   = tick && de_i && ax_last[AX_H];

  assign pix_ce  = tick;
  assign pclk_o  = pclk_raw ^ inv_pix;
  assign hsync_o = (edge_en ? hs_q : hs_live) ^ inv_line;
  assign vsync_o = (edge_en ? vs_q : vs_live) ^ inv_frame;
  assign de_o    = de_i;
  assign pos_x   = de_i ? ax_idx[AX_H] : '0;
  assign pos_y   = de_i ? ax_idx[AX_V] : '0;
  assign eol_o   = eol_i;
  assign eof_o   = eol_i && ax_last[AX_V];
  assign done_o  = done_i;
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker (
  input logic clk,
  input logic rst_n,
  input logic inv_pix,
  input logic inv_line,
  input logic edge_en,
  input logic pix_ce,
  input logic pclk_o,
  input logic hsync_o,
  input logic de_o,
  input logic eol_o,
  input logic eof_o,
  input logic done_o
);
  assert_ce_isolated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ce |=> !pix_ce);

  assert_pclk_high_at_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ce |-> (pclk_o != inv_pix));

  assert_no_line_sync_in_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (de_o && !edge_en) |-> (hsync_o == inv_line));

  assert_eol_closes_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eol_o |=> !de_o);

  assert_eof_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |=> !eof_o);

  assert_start_clears_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_o) |-> !pix_ce);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!de_o && !pix_ce && !eol_o));

  assert_done_after_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(pix_ce));
endmodule

bind raster_timing_gen rtg_checker u_rtg_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .inv_pix  (tim_x[22]),
  .inv_line (tim_x[21]),
  .edge_en  (tim_x[25]),
  .pix_ce   (pix_ce),
  .pclk_o   (pclk_o),
  .hsync_o  (hsync_o),
  .de_o     (de_o),
  .eol_o    (eol_o),
  .eof_o    (eof_o),
  .done_o   (done_o)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk;
  logic        rst_n;
  logic        run_en;
  logic [31:0] ctrl_word, tim_h, tim_v, tim_x;
  logic        pix_ce, pclk_o, hsync_o, vsync_o, de_o, eol_o, eof_o, done_o;
  logic [10:0] pos_x, pos_y;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  raster_timing_gen u_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .ctrl_word(ctrl_word), .tim_h(tim_h), .tim_v(tim_v), .tim_x(tim_x),
    .pix_ce(pix_ce), .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .pos_x(pos_x), .pos_y(pos_y),
    .eol_o(eol_o), .eof_o(eof_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // expected configuration
  int cD, cHsw, cHbp, cAct, cHfp, cVsw, cVbp, cLines, cVfp;
  int cInvP, cInvL, cInvF, cSel, cEn, htot, vtot, fcyc;

  task automatic chk(input string req, input string what, input int act, input int exp, input int t);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s t=%0d actual=%0d expected=%0d", req, what, t, act, exp);
    end
  endtask

  task automatic set_cfg(input int div, input int hpw, input int hbp, input int ppl, input int hext,
                         input int hfp, input int vpw, input int vbp, input int lpp, input int vext,
                         input int vfp, input int invp, input int invl, input int invf,
                         input int esel, input int een);
    ctrl_word = 32'(div) << 8;
    tim_h = (32'(hbp) << 24) | (32'(hfp) << 16) | (32'(hpw) << 10) | (32'(ppl) << 4) | (32'(hext) << 3);
    tim_v = (32'(vbp) << 24) | (32'(vfp) << 16) | (32'(vpw) << 10) | 32'(lpp);
    tim_x = (32'(vext) << 26) | (32'(een) << 25) | (32'(esel) << 24) |
            (32'(invp) << 22) | (32'(invl) << 21) | (32'(invf) << 20);
    cD = (div < 2) ? 2 : div;
    cHsw = hpw + 1; cHbp = hbp + 1; cHfp = hfp + 1;
    cAct = (hext * 64 + ppl + 1) * 16;
    cVsw = vpw + 1; cVbp = vbp + 1; cVfp = vfp + 1;
    cLines = vext * 1024 + lpp + 1;
    cInvP = invp; cInvL = invl; cInvF = invf; cSel = esel; cEn = een;
    htot = cHsw + cHbp + cAct + cHfp;
    vtot = cVsw + cVbp + cLines + cVfp;
    fcyc = cD * htot * vtot;
  endtask

  function automatic int h_of(input int s);
    return (s % (htot * vtot)) % htot;
  endfunction

  function automatic int v_of(input int s);
    return (s % (htot * vtot)) / htot;
  endfunction

  function automatic int hs_at(input int s);
    if (s < 0) return 0;
    return (h_of(s) < cHsw) ? 1 : 0;
  endfunction

  function automatic int vs_at(input int s);
    if (s < 0) return 0;
    return (v_of(s) < cVsw) ? 1 : 0;
  endfunction

  // sync value seen in slot s at phase ph under the edge setting (R8)
  function automatic int sync_view(input int live_now, input int live_prev, input int ph);
    if (cEn == 0) return live_now;
    if (cSel == 0) return (ph >= cD / 2) ? live_now : live_prev;
    return live_prev;
  endfunction

  task automatic check_cycle(input int t, input string hs_tag, input string vs_tag, input string de_tag);
    int s, ph, h, v, de, ex, ey, eol, eof;
    s  = t / cD;
    ph = t % cD;
    h  = h_of(s);
    v  = v_of(s);
    de = (h >= cHsw + cHbp && h < cHsw + cHbp + cAct &&
          v >= cVsw + cVbp && v < cVsw + cVbp + cLines) ? 1 : 0;
    ex = de ? h - cHsw - cHbp : 0;
    ey = de ? v - cVsw - cVbp : 0;
    eol = (ph == cD - 1 && de == 1 && h == cHsw + cHbp + cAct - 1) ? 1 : 0;
    eof = (eol == 1 && v == cVsw + cVbp + cLines - 1) ? 1 : 0;
    chk("R1", "pix_ce", int'(pix_ce), (ph == cD - 1) ? 1 : 0, t);
    chk("R2", "pclk_o", int'(pclk_o), ((ph >= cD / 2) ? 1 : 0) ^ cInvP, t);
    chk(hs_tag, "hsync_o", int'(hsync_o), sync_view(hs_at(s), hs_at(s - 1), ph) ^ cInvL, t);
    chk(vs_tag, "vsync_o", int'(vsync_o), sync_view(vs_at(s), vs_at(s - 1), ph) ^ cInvF, t);
    chk(de_tag, "de_o", int'(de_o), de, t);
    chk(de_tag, "pos_x", int'(pos_x), ex, t);
    chk(de_tag, "pos_y", int'(pos_y), ey, t);
    chk("R6", "eol_o", int'(eol_o), eol, t);
    chk("R6", "eof_o", int'(eof_o), eof, t);
    chk((t == 0) ? "R9" : "R10", "done_o", int'(done_o), 0, t);
  endtask

  task automatic check_idle(input string req, input int exp_done, input int t);
    chk(req, "done_o", int'(done_o), exp_done, t);
    chk(req, "de_o", int'(de_o), 0, t);
    chk(req, "pix_ce", int'(pix_ce), 0, t);
    chk(req, "eol_o", int'(eol_o), 0, t);
    chk(req, "eof_o", int'(eof_o), 0, t);
    chk(req, "pos_x", int'(pos_x), 0, t);
    chk(req, "pos_y", int'(pos_y), 0, t);
    chk("R7", "hsync_o idle", int'(hsync_o), int'(tim_x[21]), t);
    chk("R7", "vsync_o idle", int'(vsync_o), int'(tim_x[20]), t);
    chk("R2", "pclk_o idle", int'(pclk_o), int'(tim_x[22]), t);
  endtask

  // run nfr frames; run_en pulses low over [g_lo,g_hi) inside frame 0 (R10 ignore),
  // and drops for good one third into the last frame
  task automatic run_cfg(input int nfr, input int g_lo, input int g_hi,
                         input string hs_tag, input string vs_tag, input string de_tag);
    int total, drop_t;
    total  = nfr * fcyc;
    drop_t = (nfr - 1) * fcyc + fcyc / 3;
    @(negedge clk);
    run_en = 1'b1;
    @(posedge clk);
    for (int t = 0; t < total; t++) begin
      @(negedge clk);
      check_cycle(t, hs_tag, vs_tag, de_tag);
      if (t == g_lo) run_en = 1'b0;
      if (t == g_hi) run_en = 1'b1;
      if (t == drop_t) run_en = 1'b0;
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check_idle("R10", 1, total + k);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    run_en = 1'b0;
    set_cfg(0, 1, 0, 0, 0, 2, 0, 1, 2, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check_idle("R11", 0, -1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_idle("R11", 0, -1);

    // divisor 0 counts as two, plain polarity, run_en glitch mid frame ignored (R10)
    run_cfg(2, 40, 70, "R3", "R4", "R5");
    // divisor 1 counts as two, all inverted, syncs on the rising edge
    set_cfg(1, 0, 2, 0, 0, 0, 1, 0, 1, 0, 1, 1, 1, 1, 0, 1);
    run_cfg(2, -1, -1, "R8", "R7", "R5");
    // divisor 5, two blocks wide, syncs on the falling edge
    set_cfg(5, 2, 1, 1, 0, 1, 0, 0, 1, 0, 2, 0, 1, 0, 1, 1);
    run_cfg(2, 10, 20, "R8", "R8", "R5");
    // divisor 3, edge select without edge control has no effect
    set_cfg(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    run_cfg(2, -1, -1, "R8", "R7", "R5");
    // width extension bit: 1040 active pixels
    set_cfg(2, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_cfg(1, -1, -1, "R3", "R4", "R12");
    // height extension bit: 1025 active lines
    set_cfg(2, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    run_cfg(1, -1, -1, "R3", "R4", "R12");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule